// File: doc/BRIEF.md
# Programmable Source-Selecting Clock Divider

This block produces a divided clock-enable from one of several source strobes, all in one system clock domain. Each source is a single-cycle enable pulse on `src_tick`. The block counts the pulses of the chosen source and emits one single-cycle `tick_out` pulse for every N source pulses, with N between 1 and 64. One 32-bit control word, written through a simple write port and read back at any time, sets the divisor, the source and a halt bit.

The divisor is stored as N-1. While the block is halted the output is silent and the divisor field never holds zero. Divisor and source changes are applied only between output periods, so no period is ever cut short or stretched. Clearing the halt bit starts a fresh period from a zero count.

Top module: `clkdiv_srcsel`

## Requirements
- R1: With divisor field `wr_data[5:0]` = v and the halt bit clear, `tick_out` goes high for one cycle once per v+1 pulses of the selected source. The pulse appears in the cycle after the source pulse that completes the period.
- R2: Bit 8 of the control word is the halt bit. From the cycle after it reads 1, `tick_out` stays low, and `running` equals the inverse of bit 8.
- R3: Where the source select field sits depends on NUM_SRC. With 1 source there is no field. With 2 to 4 sources the field is bits 7:6. With 5 to 8 sources it is bits 14:12 (bits 14:12 at the default NUM_SRC = 6). Only pulses of the selected source advance the count.
- R4: A written select value equal to or above NUM_SRC is dropped and the previous selection stays. The other fields of the same write still take effect.
- R5: A write that sets the halt bit with a zero divisor field stores 63 in the divisor field. A halting write with a non-zero divisor stores that divisor unchanged.
- R6: When the halt bit is cleared, counting restarts from zero, and the first `tick_out` follows a full v+1 source pulses.
- R7: While running, a new divisor or select is used only after the current period ends, that is after the pulse that produces `tick_out`. While halted, it is used at once.
- R8: All control-word bits other than the divisor, select and halt fields read as zero, and writes to them have no effect.
- R9: After reset the control word reads 0: divide by 1, source 0, running, with `tick_out` low.
- R10: `rd_data` shows the stored control word from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | NUM_SRC | Per-source single-cycle enable strobes |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Current control word |
| running | output | 1 | High when the halt bit is clear |
| tick_out | output | 1 | Divided single-cycle output pulse |

## Verification
A stale active divisor or select shows up as a `tick_out` pulse that comes too early or too late, or that follows the wrong source. This appears within one output period of the change, at most 64 pulses of the selected source. A counter that is not cleared on restart shifts the first pulse after the halt bit is released. A wrong field latch or write mask shows on `rd_data` in the very next cycle. A cycle-accurate model in the bench compares both outputs every cycle under random source pulses and writes, and directed sequences cover forced divisors, invalid selects and mid-period changes.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int DIV_W    = 6;
  localparam int STOP_POS = 8;
  localparam int REG_W    = 32;

  // Select field width for a given number of sources.
  function automatic int sel_width(int n);
    if (n <= 1) return 1;
    else if (n <= 4) return 2;
    else return 3;
  endfunction

  // Lowest bit of the select field for a given number of sources.
  function automatic int sel_lsb(int n);
    return (n <= 4) ? 6 : 12;
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int SEL_W   = 3,
  parameter int SEL_LSB = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic               stop_q,
  output logic [DIV_W-1:0]   div_nxt,
  output logic [SEL_W-1:0]   sel_nxt,
  output logic [REG_W-1:0]   rd_data
);
  localparam logic [31:0] NSRC_U = 32'(NUM_SRC);

  logic [DIV_W-1:0] div_q;
  logic [SEL_W-1:0] sel_q;
  logic             stop_d;
  logic [SEL_W-1:0] sel_cand;
  logic             wr_stop;
  logic [DIV_W-1:0] wr_div;

  assign wr_stop = wr_data[STOP_POS];
  assign wr_div  = wr_data[DIV_W-1:0];

  generate
    if (NUM_SRC > 1) begin : g_sel
      assign sel_cand = wr_data[SEL_LSB +: SEL_W];
    end else begin : g_nosel
      assign sel_cand = '0;
    end
  endgenerate

  // Next-state decode of a write
  always_comb begin
    div_nxt = div_q;
    sel_nxt = sel_q;
    stop_d  = stop_q;
    if (wr_en) begin
      stop_d  = wr_stop;
      div_nxt = (wr_stop && (wr_div == '0)) ? '1 : wr_div;
      if (32'(sel_cand) < NSRC_U) sel_nxt = sel_cand;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sel_q  <= '0;
      stop_q <= 1'b0;
    end else if (wr_en) begin
      div_q  <= div_nxt;
      sel_q  <= sel_nxt;
      stop_q <= stop_d;
    end
  end

  always_comb begin
    rd_data              = '0;
    rd_data[DIV_W-1:0]   = div_q;
    rd_data[STOP_POS]    = stop_q;
    if (NUM_SRC > 1) rd_data[SEL_LSB +: SEL_W] = sel_q;
  end
endmodule

// File: rtl/clkdiv_tick_pick.sv
module clkdiv_tick_pick #(
  parameter int NUM_SRC = 6,
  parameter int SEL_W   = 3
) (
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   sel,
  output logic               tick
);
  localparam int PAD_N = 1 << SEL_W;

  logic [PAD_N-1:0] padded;

  generate
    for (genvar i = 0; i < PAD_N; i++) begin : g_pad
      if (i < NUM_SRC) begin : g_real
        assign padded[i] = src_tick[i];
      end else begin : g_none
        assign padded[i] = 1'b0;
      end
    end
  endgenerate

  assign tick = padded[sel];
endmodule

// File: rtl/clkdiv_srcsel.sv
module clkdiv_srcsel
  import clkdiv_pkg::*;
#(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  output logic               running,
  output logic               tick_out
);
  localparam int SEL_W   = sel_width(NUM_SRC);
  localparam int SEL_LSB = sel_lsb(NUM_SRC);

  logic             stop_q;
  logic [DIV_W-1:0] div_nxt, act_div_q, act_div_d, cnt_q, cnt_d;
  logic [SEL_W-1:0] sel_nxt, act_sel_q, act_sel_d;
  logic             sel_tick, wrap, cnt_en, pulse_d, tick_out_q;

  clkdiv_regs #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .SEL_LSB(SEL_LSB)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .stop_q  (stop_q),
    .div_nxt (div_nxt),
    .sel_nxt (sel_nxt),
    .rd_data (rd_data)
  );

  clkdiv_tick_pick #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_pick (
    .src_tick (src_tick),
    .sel      (act_sel_q),
    .tick     (sel_tick)
  );

  assign wrap   = sel_tick && (cnt_q == act_div_q);
  assign cnt_en = stop_q || sel_tick;

  // Counter next state: reload configuration only while halted or at a boundary
  always_comb begin
    cnt_d     = cnt_q;
    act_div_d = act_div_q;
    act_sel_d = act_sel_q;
    pulse_d   = 1'b0;
    if (stop_q) begin
      cnt_d     = '0;
      act_div_d = div_nxt;
      act_sel_d = sel_nxt;
    end else if (wrap) begin
      cnt_d     = '0;
      act_div_d = div_nxt;
      act_sel_d = sel_nxt;
      pulse_d   = 1'b1;
    end else if (sel_tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      act_div_q  <= '0;
      act_sel_q  <= '0;
      tick_out_q <= 1'b0;
    end else begin
      tick_out_q <= pulse_d;
      if (cnt_en) begin
        cnt_q     <= cnt_d;
        act_div_q <= act_div_d;
        act_sel_q <= act_sel_d;
      end
    end
  end

  assign running  = !stop_q;
  assign tick_out = tick_out_q;
endmodule

// File: rtl/clkdiv_srcsel_chk.sv
module clkdiv_srcsel_chk
  import clkdiv_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int SEL_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_q,
  input logic [DIV_W-1:0] act_div_q,
  input logic [SEL_W-1:0] act_sel_q,
  input logic [DIV_W-1:0] cnt_q,
  input logic             wrap,
  input logic             tick_out,
  input logic [31:0]      rd_data
);
  localparam int SEL_LSB = sel_lsb(NUM_SRC);

  a_r2_halt_silences: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> !tick_out);

  a_r5_halt_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[STOP_POS] |-> (rd_data[DIV_W-1:0] != '0));

  a_r7_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_q && !wrap) |=> ($stable(act_div_q) && $stable(act_sel_q)));

  a_r1_pulse_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> $past(wrap && !stop_q));

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= act_div_q);

  a_r6_halt_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> (cnt_q == '0));

  a_r4_sel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (NUM_SRC <= 1) || (32'(rd_data[SEL_LSB +: SEL_W]) < 32'(NUM_SRC)));
endmodule

bind clkdiv_srcsel clkdiv_srcsel_chk #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stop_q    (stop_q),
  .act_div_q (act_div_q),
  .act_sel_q (act_sel_q),
  .cnt_q     (cnt_q),
  .wrap      (wrap),
  .tick_out  (tick_out),
  .rd_data   (rd_data)
);

// File: tb/clkdiv_srcsel_bench.sv
`timescale 1ns/1ps
module clkdiv_srcsel_bench;
  localparam int NS = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_tick = '0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic          running;
  logic          tick_out;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  bit done = 0;

  // Reference model state
  logic [5:0] m_div, a_div, m_cnt;
  logic [2:0] m_sel, a_sel;
  logic       m_stop, m_pulse;

  always #2.5 clk = ~clk;

  clkdiv_srcsel #(.NUM_SRC(NS)) u_clkdiv_srcsel (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .running(running), .tick_out(tick_out)
  );

  function automatic logic [31:0] exp_rd();
    return {17'd0, 1'b0, m_sel, 3'd0, m_stop, 2'd0, m_div};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_div = '0; a_div = '0; m_cnt = '0; m_sel = '0; a_sel = '0;
    m_stop = 1'b0; m_pulse = 1'b0;
  endtask

  task automatic model_update(input logic w, input logic [31:0] d, input logic [NS-1:0] t);
    logic [5:0] nd; logic [2:0] ns; logic nst; logic tk;
    nd = m_div; ns = m_sel; nst = m_stop;
    if (w) begin
      nst = d[8];
      nd  = (d[8] && d[5:0] == 6'd0) ? 6'd63 : d[5:0];
      if (d[14:12] < 3'(NS)) ns = d[14:12];
    end
    tk = (a_sel < 3'(NS)) ? t[a_sel] : 1'b0;
    m_pulse = 1'b0;
    if (m_stop) begin
      m_cnt = '0; a_div = nd; a_sel = ns;
    end else if (tk && m_cnt == a_div) begin
      m_cnt = '0; a_div = nd; a_sel = ns; m_pulse = 1'b1;
    end else if (tk) begin
      m_cnt = m_cnt + 6'd1;
    end
    m_div = nd; m_sel = ns; m_stop = nst;
  endtask

  // Called just after a falling edge: compare, drive, advance one cycle.
  task automatic step(input logic w, input logic [31:0] d, input logic [NS-1:0] t);
    chk("R1 tick_out", {31'd0, tick_out}, {31'd0, m_pulse});
    chk("R10 rd_data", rd_data, exp_rd());
    chk("R2 running", {31'd0, running}, {31'd0, ~m_stop});
    if (tick_out) pulses++;
    wr_en = w; wr_data = d; src_tick = t;
    model_update(w, d, t);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; src_tick = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    // R9: reset state
    chk("R9 reset rd_data", rd_data, 32'h0);
    chk("R9 reset running", {31'd0, running}, 32'd1);
    chk("R9 reset tick_out", {31'd0, tick_out}, 32'd0);

    // R5: halting write with zero divisor forces all ones
    step(1, 32'h0000_0100, '0);
    chk("R5 forced divisor", rd_data, 32'h0000_013F);
    // R3/R10: divide by 4, source 2 (bits 14:12)
    step(1, 32'h0000_2003, '0);
    chk("R10 readback", rd_data, 32'h0000_2003);
    pulses = 0;
    for (int i = 0; i < 16; i++) step(0, '0, (i % 2 == 0) ? 6'b000100 : 6'b111011);
    step(0, '0, '0); step(0, '0, '0);
    chk("R3 R1 pulses on source 2", 32'(pulses), 32'd2);

    // R4: invalid select 7 is dropped
    step(1, 32'h0000_7003, '0);
    chk("R4 invalid select kept", rd_data, 32'h0000_2003);
    // R8: reserved bits ignored
    step(1, 32'hFFFF_FEC5, '0);
    chk("R8 reserved bits zero", rd_data, 32'h0000_2005);
    // R5: halting with nonzero divisor keeps it
    step(1, 32'h0000_1104, '0);
    chk("R5 nonzero divisor kept", rd_data, 32'h0000_1104);
    chk("R2 running low", {31'd0, running}, 32'd0);
    pulses = 0;
    for (int i = 0; i < 10; i++) step(0, '0, 6'b111111);
    chk("R2 silent while halted", 32'(pulses), 32'd0);

    // R6: restart from zero, divide by 5 on source 1
    step(1, 32'h0000_1004, '0);
    pulses = 0;
    for (int i = 0; i < 4; i++) step(0, '0, 6'b000010);
    step(0, '0, '0);
    chk("R6 no early pulse", 32'(pulses), 32'd0);
    step(0, '0, 6'b000010);
    step(0, '0, '0);
    chk("R6 first pulse after full period", 32'(pulses), 32'd1);

    // R7: change divisor mid-period
    pulses = 0;
    step(0, '0, 6'b000010); step(0, '0, 6'b000010);
    step(1, 32'h0000_1000, '0);
    step(0, '0, 6'b000010); step(0, '0, 6'b000010); step(0, '0, '0);
    chk("R7 old divisor still running", 32'(pulses), 32'd0);
    step(0, '0, 6'b000010); step(0, '0, '0);
    chk("R7 boundary pulse", 32'(pulses), 32'd1);
    for (int i = 0; i < 3; i++) step(0, '0, 6'b000010);
    step(0, '0, '0);
    chk("R7 new divisor applied", 32'(pulses), 32'd4);

    // Random phase
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      logic w; logic [31:0] d;
      w = ($urandom % 12) == 0;
      d = (($urandom % 8) == 0) ? $urandom : ($urandom & 32'h0000_7107);
      if (($urandom % 5) == 0) d[5:0] = 6'd0;
      step(w, d, NS'($urandom));
    end

    // R9: reset mid-run
    step(1, 32'h0000_3105, '0);
    do_reset();
    chk("R9 reset after run", rd_data, 32'h0);
    chk("R9 running after reset", {31'd0, running}, 32'd1);
    for (int i = 0; i < 8; i++) step(0, '0, 6'b000001);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule